// File: doc/BRIEF.md
# Fractional Multiplier with Sign Modes

This block multiplies two 8-bit operands and returns a 16-bit product. The product is split into an upper byte and a lower byte, which feed a fixed destination register pair. A three-bit mode input chooses how the operands are read: both unsigned, both signed, or the first signed with the second unsigned. The same input also chooses the output form. In integer form the product is returned as it is. In fractional form it is shifted left by one place, which turns two Q1.7 operands into a Q1.15 result.

A one-cycle start strobe latches the operands and the mode. Exactly two cycles later the block raises a single-cycle done pulse. In that same cycle it presents the product and the two flags that a multiply updates. The carry flag comes from the product before the fractional shift. The zero flag comes from the value that is actually delivered. Register-file writes and instruction decode sit outside the block. The product core can be built as a plain multiply operator or as an explicit shift-add array, chosen by a parameter.

Top module: `frac_mul`

## Requirements
- R1: With mode[1:0] = 00 (or the spare code 11) both operands are unsigned, and the integer result is opa × opb.
- R2: With mode[1:0] = 01 both operands are two's-complement signed, and the result is the low 16 bits of the signed product.
- R3: With mode[1:0] = 10 the first operand is signed and the second is unsigned, and the result is the low 16 bits of that mixed product.
- R4: With mode[2] = 1 the 16-bit product is shifted left by one place and bit 0 becomes 0. Signed fractional mode with both operands 0x80 gives 0x8000.
- R5: The upper result byte appears on prod_hi_o and the lower byte on prod_lo_o.
- R6: flag_c_o equals bit 15 of the product before any fractional shift.
- R7: flag_z_o is 1 exactly when the delivered 16-bit result is zero.
- R8: done_o is high for exactly one cycle, two cycles after the cycle in which an accepted start was high. The product and flags are valid in that cycle.
- R9: A start in the cycle directly after an accepted start is ignored and produces no done. A start in a done cycle is accepted.
- R10: After reset, done_o, both result bytes and both flags are 0. Between done pulses the result and flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; latches operands and mode |
| mode_i | input | 3 | [2] fractional, [1:0] sign selection |
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand |
| done_o | output | 1 | One-cycle result-valid pulse |
| prod_hi_o | output | W | Upper half of the result |
| prod_lo_o | output | W | Lower half of the result |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
Every result is due in the second cycle after the cycle in which its start was driven. The done pulse, both bytes and both flags all change on the same clock edge. The driver records that due cycle with each expected item. The monitor samples on the falling clock edge and reports a done pulse that arrives early, late or without a matching item. Ignored starts and the hold behaviour are checked by watching the outputs over the cycles after the stimulus, where an extra done pulse or a changed byte would appear.

// File: rtl/frac_mul_pkg.sv
package frac_mul_pkg;

   typedef enum logic [1:0] {
      SGN_UU  = 2'b00,
      SGN_SS  = 2'b01,
      SGN_SU  = 2'b10,
      SGN_SPR = 2'b11
   } sgn_sel_e;

   typedef struct packed {
      logic     frac;
      sgn_sel_e sgn;
   } mode_t;

   localparam int unsigned MODE_BITS = $bits(mode_t);

endpackage

// File: rtl/frac_mul_opnd.sv
module frac_mul_opnd
   import frac_mul_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0]  opa,
   input  logic [W-1:0]  opb,
   input  sgn_sel_e      sgn,
   output logic [W:0]    opa_x,
   output logic [W:0]    opb_x
);

   logic a_is_signed;
   logic b_is_signed;

   always_comb begin
      a_is_signed = (sgn == SGN_SS) || (sgn == SGN_SU);
      b_is_signed = (sgn == SGN_SS);
   end

   // one extra bit per operand lets a single signed core cover all modes
   assign opa_x = {a_is_signed & opa[W-1], opa};
   assign opb_x = {b_is_signed & opb[W-1], opb};

endmodule

// File: rtl/frac_mul_core.sv
module frac_mul_core #(
   parameter int unsigned W         = 8,
   parameter bit          ARRAY_IMP = 1'b0
) (
   input  logic [W:0]     opa_x,
   input  logic [W:0]     opb_x,
   output logic [2*W-1:0] prod
);

   localparam int unsigned XW = W + 1;
   localparam int unsigned FW = 2 * XW;

   logic [FW-1:0] full;

   generate
      if (!ARRAY_IMP) begin : g_operator
         logic signed [FW-1:0] sa;
         logic signed [FW-1:0] sb;
         always_comb begin
            sa   = FW'($signed(opa_x));
            sb   = FW'($signed(opb_x));
            full = sa * sb;
         end
      end else begin : g_array
         logic [FW-1:0] a_ext;
         always_comb begin
            a_ext = {{XW{opa_x[W]}}, opa_x};
            full  = '0;
            for (int i = 0; i < W; i++) begin
               if (opb_x[i]) full = full + (a_ext << i);
            end
            // top bit of the extended multiplier carries negative weight
            if (opb_x[W]) full = full - (a_ext << W);
         end
      end
   endgenerate

   assign prod = full[2*W-1:0];

endmodule

// File: rtl/frac_mul_flags.sv
module frac_mul_flags #(
   parameter int unsigned W = 8
) (
   input  logic [2*W-1:0] raw,
   input  logic           frac,
   output logic [2*W-1:0] res,
   output logic           zero,
   output logic           carry
);

   always_comb begin
      carry = raw[2*W-1];
      res   = frac ? {raw[2*W-2:0], 1'b0} : raw;
      zero  = (res == '0);
   end

endmodule

// File: rtl/frac_mul.sv
module frac_mul
   import frac_mul_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter bit          ARRAY_IMP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [2:0]    mode_i,
   input  logic [W-1:0]  opa_i,
   input  logic [W-1:0]  opb_i,
   output logic          done_o,
   output logic [W-1:0]  prod_hi_o,
   output logic [W-1:0]  prod_lo_o,
   output logic          flag_z_o,
   output logic          flag_c_o
);

   localparam int unsigned PW = 2 * W;

   generate
      if (W < 2) begin : g_bad_width
         $error("frac_mul: W must be at least 2");
      end
      if (MODE_BITS != 3) begin : g_bad_mode
         $error("frac_mul: mode field must be 3 bits");
      end
   endgenerate

   // stage 1: operand capture
   logic          s1_v;
   logic [W-1:0]  s1_a;
   logic [W-1:0]  s1_b;
   mode_t         s1_mode;
   logic          s1_frac;
   logic          accept;

   assign accept  = start_i && !s1_v;
   assign s1_frac = s1_mode.frac;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_a    <= '0;
         s1_b    <= '0;
         s1_mode <= '0;
      end else begin
         s1_v <= accept;
         if (accept) begin
            s1_a    <= opa_i;
            s1_b    <= opb_i;
            s1_mode <= mode_t'(mode_i);
         end
      end
   end

   // stage 2: multiply, shift, flags
   logic [W:0]    a_x;
   logic [W:0]    b_x;
   logic [PW-1:0] raw;
   logic [PW-1:0] res;
   logic          z_n;
   logic          c_n;

   frac_mul_opnd #(.W(W)) u_opnd (
      .opa   (s1_a),
      .opb   (s1_b),
      .sgn   (s1_mode.sgn),
      .opa_x (a_x),
      .opb_x (b_x)
   );

   frac_mul_core #(.W(W), .ARRAY_IMP(ARRAY_IMP)) u_core (
      .opa_x (a_x),
      .opb_x (b_x),
      .prod  (raw)
   );

   frac_mul_flags #(.W(W)) u_flags (
      .raw   (raw),
      .frac  (s1_frac),
      .res   (res),
      .zero  (z_n),
      .carry (c_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         prod_hi_o <= '0;
         prod_lo_o <= '0;
         flag_z_o  <= 1'b0;
         flag_c_o  <= 1'b0;
      end else begin
         done_o <= s1_v;
         if (s1_v) begin
            prod_hi_o <= res[PW-1:W];
            prod_lo_o <= res[W-1:0];
            flag_z_o  <= z_n;
            flag_c_o  <= c_n;
         end
      end
   end

endmodule

// File: rtl/frac_mul_chk.sv
module frac_mul_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         s1_v,
   input logic         s1_frac,
   input logic         done_o,
   input logic [W-1:0] prod_hi_o,
   input logic [W-1:0] prod_lo_o,
   input logic         flag_z_o,
   input logic         flag_c_o
);

   // R8
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !s1_v) |=> ##1 done_o);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_v && start_i) |=> !s1_v);

   // R7
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (flag_z_o == ({prod_hi_o, prod_lo_o} == '0)));

   // R4
   frac_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(s1_frac)) |-> (prod_lo_o[0] == 1'b0));

   // R6
   int_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !$past(s1_frac)) |-> (flag_c_o == prod_hi_o[W-1]));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({prod_hi_o, prod_lo_o, flag_z_o, flag_c_o}));

endmodule

bind frac_mul frac_mul_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .s1_v      (s1_v),
   .s1_frac   (s1_frac),
   .done_o    (done_o),
   .prod_hi_o (prod_hi_o),
   .prod_lo_o (prod_lo_o),
   .flag_z_o  (flag_z_o),
   .flag_c_o  (flag_c_o)
);

// File: tb/frac_mul_test.sv
module frac_mul_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] mode_i = '0;
   logic [7:0] opa_i = '0;
   logic [7:0] opb_i = '0;
   logic       done_o;
   logic [7:0] prod_hi_o;
   logic [7:0] prod_lo_o;
   logic       flag_z_o;
   logic       flag_c_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   typedef struct {
      logic [15:0] res;
      logic        z;
      logic        c;
      int          due;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t last_exp;

   frac_mul uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mode_i    (mode_i),
      .opa_i     (opa_i),
      .opb_i     (opb_i),
      .done_o    (done_o),
      .prod_hi_o (prod_hi_o),
      .prod_lo_o (prod_lo_o),
      .flag_z_o  (flag_z_o),
      .flag_c_o  (flag_c_o)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // reference taken from the requirement text
   function automatic exp_t model(logic [7:0] a, logic [7:0] b, logic [2:0] m);
      exp_t e;
      int av, bv, p;
      logic [15:0] raw;
      av = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
      bv = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
      p = av * bv;
      raw = p[15:0];
      e.c = raw[15];
      e.res = m[2] ? {raw[14:0], 1'b0} : raw;
      e.z = (e.res == 16'h0000);
      e.due = 0;
      e.tag = "";
      return e;
   endfunction

   function automatic string mode_tag(logic [2:0] m);
      string s;
      case (m[1:0])
         2'b01:   s = "R2";
         2'b10:   s = "R3";
         default: s = "R1";
      endcase
      if (m[2]) s = {s, "+R4"};
      return s;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic issue(logic [7:0] a, logic [7:0] b, logic [2:0] m);
      exp_t e;
      @(negedge clk);
      opa_i = a; opb_i = b; mode_i = m; start_i = 1'b1;
      e = model(a, b, m);
      e.due = cyc + 2;
      e.tag = mode_tag(m);
      exp_q.push_back(e);
      @(negedge clk);
      start_i = 1'b0;
      opa_i = $urandom; opb_i = $urandom;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (exp_q.size() != 0 && exp_q[0].due < cyc) begin
            check(0, "R8", "done missing", 0, exp_q[0].due);
            void'(exp_q.pop_front());
         end
         if (done_o) begin
            if (exp_q.size() == 0) begin
               check(0, "R9", "unexpected done", {prod_hi_o, prod_lo_o}, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(cyc == e.due, "R8", "done cycle", cyc, e.due);
               check({prod_hi_o, prod_lo_o} == e.res, {e.tag, " R5"}, "product",
                     {prod_hi_o, prod_lo_o}, e.res);
               check(flag_c_o == e.c, "R6", "carry", flag_c_o, e.c);
               check(flag_z_o == e.z, "R7", "zero", flag_z_o, e.z);
               last_exp = e;
            end
         end
      end
   end

   task automatic run_all();
      logic [7:0] corners [6];
      corners = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF};

      // R10 reset state
      @(negedge clk);
      check(done_o == 1'b0, "R10", "reset done", done_o, 0);
      check({prod_hi_o, prod_lo_o} == 16'h0, "R10", "reset product",
            {prod_hi_o, prod_lo_o}, 0);
      check({flag_z_o, flag_c_o} == 2'b00, "R10", "reset flags",
            {flag_z_o, flag_c_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 explicit corner: signed fractional 0x80 * 0x80
      issue(8'h80, 8'h80, 3'b101);
      repeat (3) @(negedge clk);
      check({prod_hi_o, prod_lo_o} == 16'h8000, "R4", "0x80*0x80 frac",
            {prod_hi_o, prod_lo_o}, 16'h8000);

      // corners in every mode, spare code included, back to back (R9 accept in done cycle)
      for (int m = 0; m < 8; m++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               issue(corners[i], corners[j], 3'(m));

      // random operands, all modes
      for (int n = 0; n < 12000; n++)
         issue(8'($urandom), 8'($urandom), 3'($urandom_range(0, 7)));

      // R9 start while busy is ignored
      repeat (3) @(negedge clk);
      begin
         exp_t e;
         @(negedge clk);
         opa_i = 8'h12; opb_i = 8'h34; mode_i = 3'b000; start_i = 1'b1;
         e = model(8'h12, 8'h34, 3'b000);
         e.due = cyc + 2;
         e.tag = "R9";
         exp_q.push_back(e);
         @(negedge clk);
         opa_i = 8'hFF; opb_i = 8'hFF; mode_i = 3'b001;
         @(negedge clk);
         start_i = 1'b0;
      end
      repeat (4) @(negedge clk);
      check({prod_hi_o, prod_lo_o} == 16'h03A8, "R9", "busy start leaked",
            {prod_hi_o, prod_lo_o}, 16'h03A8);

      // R10 hold between pulses
      repeat (5) @(negedge clk);
      check({prod_hi_o, prod_lo_o} == last_exp.res, "R10", "held product",
            {prod_hi_o, prod_lo_o}, last_exp.res);
      check(flag_c_o == last_exp.c && flag_z_o == last_exp.z, "R10", "held flags",
            {flag_z_o, flag_c_o}, {last_exp.z, last_exp.c});
      check(exp_q.size() == 0, "R8", "pending results", exp_q.size(), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            check(0, "R8", "watchdog expired", cyc, 0);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule